// File: doc/BRIEF.md
# SDRAM Self-Refresh Entry Sequencer

This block brings a two-rank DDR memory controller into self-refresh ahead of a low-power sleep, without help from software. A single-cycle start request launches a fixed script of register accesses on a simple request/acknowledge port into the controller. The script first shuts every host port and turns off on-die termination. It then precharges all banks, stops auto-refresh and fences further DRAM access. Next it issues the self-refresh command to both ranks and waits until the controller reports that both ranks are in self-refresh. Finally it drops the two DRAM clock enables.

Each access is held on the port until the controller acknowledges it. Reads serve two purposes: the read-modify-write steps use them, and so does the status poll. When the clock enables are cleared a one-cycle done pulse tells the power manager that the chip may now sleep. The register offsets are parameters, so the same sequencer fits other controller address maps.

Top module: `sr_entry_seq`

## Requirements
- R1: While and after reset, before any start request, `mc_req_o`, `busy_o` and `done_o` are low and no access is issued.
- R2: With default parameters the register offsets are: main configuration 0x00, access configuration 0x04, status 0x08, auto-refresh 0x0C, port configuration 0x10, rank-0 command 0x20, rank-1 command 0x24.
- R3: Once `mc_req_o` rises, it stays high with `mc_we_o`, `mc_addr_o` and `mc_wdata_o` unchanged until a cycle in which `mc_ack_i` is high. Each acknowledged request counts as exactly one access.
- R4: The script opens with three writes, in this order: zero to port configuration, then 0x03010000 to the rank-0 command register, then 0x03010000 to the rank-1 command register.
- R5: Next come three more writes: 0x23000400 to the rank-1 command register, then the same word to the rank-0 command register, then zero to the auto-refresh register.
- R6: Access is then fenced by reading the access configuration register and writing back the value read, ORed with 0x000000BF (bit 7 and bits 5:0).
- R7: Self-refresh is then requested by writing 0x10000000 to the rank-1 command register and then to the rank-0 command register.
- R8: The status register is read repeatedly. The next step starts only after a read that returns both bit 25 and bit 24 set; any other value causes another status read.
- R9: Finally the main configuration register is read and written back with bits 29:28 cleared and all other bits as read.
- R10: `done_o` is high for exactly one cycle, in the cycle after the acknowledge of the final write. `busy_o` is high from the cycle after an accepted start until the done cycle inclusive.
- R11: A start request is accepted only when `busy_o` is low. A start during a sequence has no effect on the accesses issued or on the number of done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run the entry script |
| busy_o | output | 1 | Script in progress |
| done_o | output | 1 | One-cycle pulse after the clock enables are cleared |
| mc_req_o | output | 1 | Access request to the memory controller |
| mc_we_o | output | 1 | 1 = write, 0 = read |
| mc_addr_o | output | ADDR_W | Register offset of the access |
| mc_wdata_o | output | 32 | Write data |
| mc_ack_i | input | 1 | Access acknowledge, one cycle |
| mc_rdata_i | input | 32 | Read data, valid with the acknowledge |

## Verification
On every cycle, the assertions check several properties. They check that a pending request and its address, direction and data hold steady until acknowledged. They check that any write of the main configuration register carries cleared clock enables, and that any write to a rank command register carries one of the three script words. They also check that done lasts one cycle and directly follows a write acknowledge. Only the bench scenarios can show the exact order of the script, the read-modify-write values and the number of status polls against the controller's answers. The same holds for starts arriving mid-sequence having no effect, under random acknowledge latencies.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

  localparam int unsigned DATA_W = 32;

  localparam logic [DATA_W-1:0] CMD_ODT_OFF  = 32'h0301_0000;
  localparam logic [DATA_W-1:0] CMD_PRE_ALL  = 32'h2300_0400;
  localparam logic [DATA_W-1:0] CMD_SELF_REF = 32'h1000_0000;
  localparam logic [DATA_W-1:0] FENCE_BITS   = 32'h0000_00BF;
  localparam logic [DATA_W-1:0] CKE_BITS     = 32'h3000_0000;
  localparam logic [DATA_W-1:0] SR_READY     = 32'h0300_0000;

  typedef enum logic [1:0] {
    FSM_IDLE,
    FSM_LAUNCH,
    FSM_WAIT,
    FSM_DONE
  } fsm_state_e;

  typedef enum logic [3:0] {
    STP_PORT_OFF,
    STP_ODT_RK0,
    STP_ODT_RK1,
    STP_PRE_RK1,
    STP_PRE_RK0,
    STP_AREF_OFF,
    STP_FENCE_RD,
    STP_FENCE_WR,
    STP_SREF_RK1,
    STP_SREF_RK0,
    STP_STAT_POLL,
    STP_CKE_RD,
    STP_CKE_WR
  } step_e;

  typedef enum logic [2:0] {
    RID_MAINCFG,
    RID_ACCCFG,
    RID_STATUS,
    RID_AREF,
    RID_PORTCFG,
    RID_CMD_RK0,
    RID_CMD_RK1
  } reg_id_e;

  typedef enum logic [1:0] {
    WD_CONST,
    WD_OR_READ,
    WD_CLR_READ
  } wdata_sel_e;

  typedef struct packed {
    logic              we;
    reg_id_e           rid;
    wdata_sel_e        sel;
    logic [DATA_W-1:0] konst;
  } step_desc_t;

endpackage

// File: rtl/sr_step_rom.sv
module sr_step_rom
  import sr_seq_pkg::*;
(
  input  step_e      step_i,
  output step_desc_t desc_o,
  output logic       is_last_o,
  output logic       is_poll_o
);

  always_comb begin
    desc_o = '{we: 1'b1, rid: RID_PORTCFG, sel: WD_CONST, konst: '0};
    unique case (step_i)
      STP_PORT_OFF:  desc_o = '{we: 1'b1, rid: RID_PORTCFG, sel: WD_CONST,    konst: '0};
      STP_ODT_RK0:   desc_o = '{we: 1'b1, rid: RID_CMD_RK0, sel: WD_CONST,    konst: CMD_ODT_OFF};
      STP_ODT_RK1:   desc_o = '{we: 1'b1, rid: RID_CMD_RK1, sel: WD_CONST,    konst: CMD_ODT_OFF};
      STP_PRE_RK1:   desc_o = '{we: 1'b1, rid: RID_CMD_RK1, sel: WD_CONST,    konst: CMD_PRE_ALL};
      STP_PRE_RK0:   desc_o = '{we: 1'b1, rid: RID_CMD_RK0, sel: WD_CONST,    konst: CMD_PRE_ALL};
      STP_AREF_OFF:  desc_o = '{we: 1'b1, rid: RID_AREF,    sel: WD_CONST,    konst: '0};
      STP_FENCE_RD:  desc_o = '{we: 1'b0, rid: RID_ACCCFG,  sel: WD_CONST,    konst: '0};
      STP_FENCE_WR:  desc_o = '{we: 1'b1, rid: RID_ACCCFG,  sel: WD_OR_READ,  konst: FENCE_BITS};
      STP_SREF_RK1:  desc_o = '{we: 1'b1, rid: RID_CMD_RK1, sel: WD_CONST,    konst: CMD_SELF_REF};
      STP_SREF_RK0:  desc_o = '{we: 1'b1, rid: RID_CMD_RK0, sel: WD_CONST,    konst: CMD_SELF_REF};
      STP_STAT_POLL: desc_o = '{we: 1'b0, rid: RID_STATUS,  sel: WD_CONST,    konst: '0};
      STP_CKE_RD:    desc_o = '{we: 1'b0, rid: RID_MAINCFG, sel: WD_CONST,    konst: '0};
      STP_CKE_WR:    desc_o = '{we: 1'b1, rid: RID_MAINCFG, sel: WD_CLR_READ, konst: CKE_BITS};
      default:       desc_o = '{we: 1'b1, rid: RID_PORTCFG, sel: WD_CONST,    konst: '0};
    endcase
  end

  assign is_last_o = (step_i == STP_CKE_WR);
  assign is_poll_o = (step_i == STP_STAT_POLL);

endmodule

// File: rtl/sr_bus_master.sv
module sr_bus_master
  import sr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              xfer_done_o,
  output logic [DATA_W-1:0] rdata_q_o
);

  logic              req_q,   req_d;
  logic              we_q,    we_d;
  logic [ADDR_W-1:0] addr_q,  addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              load_en, cap_en;

  assign xfer_done_o = req_q & ack_i;
  assign load_en     = launch_i & ~req_q;
  assign cap_en      = xfer_done_o & ~we_q;

  always_comb begin
    req_d   = req_q;
    we_d    = we_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    if (load_en) begin
      req_d   = 1'b1;
      we_d    = we_i;
      addr_d  = addr_i;
      wdata_d = wdata_i;
    end else if (xfer_done_o) begin
      req_d = 1'b0;
    end
    if (cap_en) begin
      rdata_d = rdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      req_q   <= req_d;
      we_q    <= we_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
    end
  end

  assign req_o     = req_q;
  assign we_o      = we_q;
  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;
  assign rdata_q_o = rdata_q;

  // R3: a pending access keeps its attributes until acknowledged
  a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack_i) |=> (req_q && $stable(addr_q) && $stable(we_q) && $stable(wdata_q)));

  // R3: the sequencer never launches over an outstanding access
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |-> !req_q);

endmodule

// File: rtl/sr_entry_seq.sv
module sr_entry_seq
  import sr_seq_pkg::*;
#(
  parameter int unsigned     ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OFS_MAINCFG = 8'h00,
  parameter logic [ADDR_W-1:0] OFS_ACCCFG  = 8'h04,
  parameter logic [ADDR_W-1:0] OFS_STATUS  = 8'h08,
  parameter logic [ADDR_W-1:0] OFS_AREF    = 8'h0C,
  parameter logic [ADDR_W-1:0] OFS_PORTCFG = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_CMD_RK0 = 8'h20,
  parameter logic [ADDR_W-1:0] OFS_CMD_RK1 = 8'h24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mc_req_o,
  output logic              mc_we_o,
  output logic [ADDR_W-1:0] mc_addr_o,
  output logic [DATA_W-1:0] mc_wdata_o,
  input  logic              mc_ack_i,
  input  logic [DATA_W-1:0] mc_rdata_i
);

  fsm_state_e state_q, state_d;
  step_e      step_q,  step_d;
  step_desc_t desc;
  logic       is_last, is_poll;
  logic       launch, xfer_done, poll_ready;
  logic [ADDR_W-1:0] step_addr;
  logic [DATA_W-1:0] step_wdata, rdata_q;

  sr_step_rom u_rom (
    .step_i    (step_q),
    .desc_o    (desc),
    .is_last_o (is_last),
    .is_poll_o (is_poll)
  );

  always_comb begin
    unique case (desc.rid)
      RID_MAINCFG: step_addr = OFS_MAINCFG;
      RID_ACCCFG:  step_addr = OFS_ACCCFG;
      RID_STATUS:  step_addr = OFS_STATUS;
      RID_AREF:    step_addr = OFS_AREF;
      RID_PORTCFG: step_addr = OFS_PORTCFG;
      RID_CMD_RK0: step_addr = OFS_CMD_RK0;
      RID_CMD_RK1: step_addr = OFS_CMD_RK1;
      default:     step_addr = OFS_PORTCFG;
    endcase
  end

  always_comb begin
    unique case (desc.sel)
      WD_OR_READ:  step_wdata = rdata_q | desc.konst;
      WD_CLR_READ: step_wdata = rdata_q & ~desc.konst;
      default:     step_wdata = desc.konst;
    endcase
  end

  assign launch = (state_q == FSM_LAUNCH);

  sr_bus_master #(.ADDR_W(ADDR_W)) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch_i    (launch),
    .we_i        (desc.we),
    .addr_i      (step_addr),
    .wdata_i     (step_wdata),
    .ack_i       (mc_ack_i),
    .rdata_i     (mc_rdata_i),
    .req_o       (mc_req_o),
    .we_o        (mc_we_o),
    .addr_o      (mc_addr_o),
    .wdata_o     (mc_wdata_o),
    .xfer_done_o (xfer_done),
    .rdata_q_o   (rdata_q)
  );

  assign poll_ready = ((mc_rdata_i & SR_READY) == SR_READY);

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    unique case (state_q)
      FSM_IDLE: begin
        if (start_i) begin
          state_d = FSM_LAUNCH;
          step_d  = STP_PORT_OFF;
        end
      end
      FSM_LAUNCH: state_d = FSM_WAIT;
      FSM_WAIT: begin
        if (xfer_done) begin
          if (is_poll && !poll_ready) begin
            state_d = FSM_LAUNCH;
          end else if (is_last) begin
            state_d = FSM_DONE;
          end else begin
            state_d = FSM_LAUNCH;
            step_d  = step_e'(step_q + 4'd1);
          end
        end
      end
      FSM_DONE: state_d = FSM_IDLE;
      default:  state_d = FSM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FSM_IDLE;
      step_q  <= STP_PORT_OFF;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign busy_o = (state_q != FSM_IDLE);
  assign done_o = (state_q == FSM_DONE);

  // R10: done is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10: done directly follows the acknowledge of a write
  a_r10_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(mc_req_o && mc_ack_i && mc_we_o));

  // R9: any write to the main configuration has both clock enables cleared
  a_r9_cke_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_req_o && mc_we_o && mc_addr_o == OFS_MAINCFG) |-> ((mc_wdata_o & CKE_BITS) == '0));

  // R7: rank command writes only carry script words
  a_r7_cmd_words: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_req_o && mc_we_o && (mc_addr_o == OFS_CMD_RK0 || mc_addr_o == OFS_CMD_RK1)) |->
    (mc_wdata_o == CMD_ODT_OFF || mc_wdata_o == CMD_PRE_ALL || mc_wdata_o == CMD_SELF_REF));

  // R11: an idle start is accepted, a busy one does not restart
  a_r11_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && !mc_req_o));

  // R1: no access while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mc_req_o);

endmodule

// File: tb/sr_entry_seq_tb_top.sv
module sr_entry_seq_tb_top;

  localparam int AW = 8;
  localparam logic [AW-1:0] A_MAIN = 8'h00, A_ACC = 8'h04, A_STAT = 8'h08,
                            A_AREF = 8'h0C, A_PORT = 8'h10, A_RK0 = 8'h20, A_RK1 = 8'h24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, req, we, ack;
  logic [AW-1:0] addr;
  logic [31:0] wdata, rdata;

  always #2 clk = ~clk;

  sr_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .mc_req_o(req), .mc_we_o(we), .mc_addr_o(addr), .mc_wdata_o(wdata),
    .mc_ack_i(ack), .mc_rdata_i(rdata)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // controller model state
  logic [31:0] m_main, m_acc;
  int          m_polls_needed, m_poll_idx;
  int          n_log;
  logic        log_we [64];
  logic [AW-1:0] log_addr [64];
  logic [31:0] log_data [64];
  int          last_ack_cyc;
  int          done_cnt, done_cyc;
  bit          done_prev;

  initial begin
    bit pend = 0;
    int lat = 0;
    logic [AW-1:0] p_addr;
    logic p_we;
    logic [31:0] p_data, st;
    ack = 0;
    rdata = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        ack = 0; pend = 0; lat = 0;
      end else if (ack) begin
        ack = 0;
      end else if (req) begin
        if (!pend) begin
          pend = 1; p_addr = addr; p_we = we; p_data = wdata;
        end else if (addr !== p_addr || we !== p_we || wdata !== p_data) begin
          check(0, "R3", "request changed before ack", {addr, wdata}, {p_addr, p_data});
        end
        if (lat == 0) begin
          ack = 1;
          pend = 0;
          lat = $urandom_range(0, 3);
          last_ack_cyc = cyc;
          if (!we) begin
            if (addr == A_MAIN) rdata = m_main;
            else if (addr == A_ACC) rdata = m_acc;
            else if (addr == A_STAT) begin
              st = $urandom;
              if (m_poll_idx < m_polls_needed)
                st = (m_poll_idx % 2 == 0) ? (st & ~32'h0200_0000) : (st & ~32'h0100_0000);
              else
                st = st | 32'h0300_0000;
              m_poll_idx++;
              rdata = st;
            end else rdata = $urandom;
          end
          if (n_log < 64) begin
            log_we[n_log] = we; log_addr[n_log] = addr;
            log_data[n_log] = we ? wdata : rdata;
          end
          n_log++;
        end else lat--;
      end
    end
  end

  initial begin
    done_cnt = 0; done_prev = 0; done_cyc = 0;
    forever begin
      @(negedge clk);
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
        if (done_prev) check(0, "R10", "done wider than one cycle", 1, 0);
      end
      done_prev = done;
    end
  end

  function automatic void exp_entry(input int i, input int np, input logic [31:0] mv,
      input logic [31:0] av, output logic e_we, output logic [AW-1:0] e_a,
      output logic [31:0] e_d, output string rq);
    e_d = '0; e_we = 1;
    case (i)
      0: begin e_a = A_PORT; e_d = 0;            rq = "R4"; end
      1: begin e_a = A_RK0;  e_d = 32'h0301_0000; rq = "R4"; end
      2: begin e_a = A_RK1;  e_d = 32'h0301_0000; rq = "R4"; end
      3: begin e_a = A_RK1;  e_d = 32'h2300_0400; rq = "R5"; end
      4: begin e_a = A_RK0;  e_d = 32'h2300_0400; rq = "R5"; end
      5: begin e_a = A_AREF; e_d = 0;            rq = "R5"; end
      6: begin e_a = A_ACC;  e_we = 0;             rq = "R6"; end
      7: begin e_a = A_ACC;  e_d = av | 32'hBF;    rq = "R6"; end
      8: begin e_a = A_RK1;  e_d = 32'h1000_0000; rq = "R7"; end
      9: begin e_a = A_RK0;  e_d = 32'h1000_0000; rq = "R7"; end
      default: begin
        if (i <= 10 + np) begin e_a = A_STAT; e_we = 0; rq = "R8"; end
        else if (i == 11 + np) begin e_a = A_MAIN; e_we = 0; rq = "R9"; end
        else begin e_a = A_MAIN; e_d = mv & ~32'h3000_0000; rq = "R9"; end
      end
    endcase
  endfunction

  task automatic run_seq(input int np, input logic [31:0] mv, input logic [31:0] av,
                         input int restart_after);
    int exp_n = 13 + np;
    int base_done;
    bit got;
    m_polls_needed = np; m_poll_idx = 0; m_main = mv; m_acc = av;
    n_log = 0;
    base_done = done_cnt;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    check(busy === 1'b1, "R11", "busy after idle start", busy, 1);
    if (restart_after > 0) begin
      repeat (restart_after) @(negedge clk);
      start = 1;
      @(negedge clk) start = 0;
    end
    got = 0;
    for (int k = 0; k < 3000 && !got; k++) begin
      @(negedge clk);
      if (done_cnt != base_done) got = 1;
    end
    check(got, "R10", "done within time limit", got, 1);
    check(done_cyc == last_ack_cyc + 1, "R10", "done one cycle after last ack",
          done_cyc, last_ack_cyc + 1);
    repeat (20) @(negedge clk);
    check(done_cnt - base_done == 1, "R11", "done pulses per sequence",
          done_cnt - base_done, 1);
    check(busy === 1'b0, "R10", "busy low after done", busy, 0);
    check(n_log == exp_n, "R8", "access count", n_log, exp_n);
    for (int i = 0; i < exp_n && i < n_log && i < 64; i++) begin
      logic e_we; logic [AW-1:0] e_a; logic [31:0] e_d; string rq;
      exp_entry(i, np, mv, av, e_we, e_a, e_d, rq);
      check(log_we[i] === e_we && log_addr[i] === e_a, rq, $sformatf("access %0d kind/addr", i),
            {log_we[i], log_addr[i]}, {e_we, e_a});
      if (e_we)
        check(log_data[i] === e_d, rq, $sformatf("access %0d data", i), log_data[i], e_d);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R10", "watchdog expired", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    n_log = 0; m_polls_needed = 0; m_poll_idx = 0; m_main = 0; m_acc = 0;
    last_ack_cyc = 0;
    repeat (3) @(negedge clk);
    check(req === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", "outputs in reset",
          {req, busy, done}, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    check(req === 1'b0 && busy === 1'b0 && n_log == 0, "R1", "quiet after reset",
          {req, busy, n_log[7:0]}, 0);
    // R2 offsets are exercised by every address check below
    run_seq(0, 32'hFFFF_FFFF, 32'h0000_0000, 0);
    run_seq(3, 32'h0000_0000, 32'hFFFF_FF40, 0);
    run_seq(1, 32'h3000_0001, 32'h0000_0040, 5);   // R11 start while busy
    for (int t = 0; t < 8; t++) begin
      run_seq($urandom_range(0, 5), $urandom, $urandom,
              ($urandom_range(0, 1) == 1) ? $urandom_range(1, 40) : 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule